// File: doc/BRIEF.md
# I2C Register Target with Region-Sized Auto-Increment

This block is an I2C target that gives a bus master access to a small on-chip register store through a 16-bit subaddress. SCL and SDA pass through synchronisers. The block then detects start, repeated start and stop conditions. It compares the first byte after a start with its own 7-bit chip address.

A write transaction has this order: the address byte with the direction bit at 0, the subaddress high byte, the subaddress low byte, and then any number of data bytes. A read first sets the subaddress with a write-direction header. The master then issues a repeated start and sends the address byte with the direction bit at 1. The target then shifts out bytes for as long as the master acknowledges them.

The pointer does not always step by one. Subaddresses below 0x4000 name single-byte registers, and the pointer advances after every byte. Subaddresses at 0x4000 and above name 16-bit words, which travel most significant byte first, and the pointer advances only after both bytes of a word. SDA is driven open-drain through an active-high pull-low enable.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, and while no transaction addresses the target, the pull-low enable `sda_oe` is 0.
- R2: An address byte whose upper seven bits equal the parameter `CHIP_ADDR` is acknowledged by pulling SDA low during the ninth SCL pulse. Bit 0 of that byte selects the direction: 0 for write, 1 for read.
- R3: An address byte that does not match is not acknowledged. Until the next start, later bytes are not acknowledged and no register changes.
- R4: In a write, the two subaddress bytes (high byte first) and every data byte are each acknowledged on the ninth pulse, and each data byte is stored at the current pointer.
- R5: For pointer values below 0x4000, the register is a byte selected by the pointer's low `LO_AW` bits, and the pointer increments by one after each data byte written or read.
- R6: For pointer values at or above 0x4000, the pointer's low `HI_AW` bits select a 16-bit word. The first byte of each word is bits 15:8 and the second is bits 7:0, and the pointer increments by one only after the second byte.
- R7: After a repeated start with a matching address and direction bit 1, the target drives the byte at the pointer, MSB first. Each master ACK on the ninth pulse advances the pointer and starts the next byte.
- R8: A master NACK on a read byte makes the target release SDA and stay silent until a start or stop. The pointer is not advanced, so a following read returns the same byte again.
- R9: A stop ends any transaction and returns the target to idle. The pointer keeps its value, so a read that starts without a subaddress continues from it.
- R10: The target changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A corrupted pointer, a wrong region decode or a wrong lane shows up in the first data byte that the master reads back after the fault: the byte at the ports belongs to a neighbouring register, or its two halves arrive swapped. A wrong protocol phase appears within one byte time, as a missing or extra acknowledge on the ninth pulse, or as SDA held low when the master expects it released. The bench replays every transaction against a behavioural memory and pointer. On every clock it also checks that `sda_oe` is low when the target should be silent and steady while SCL is high.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;
    localparam int SUB_W = 16;
    localparam logic [SUB_W-1:0] WORD_BASE = 16'h4000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUBH,
        PH_SUBL,
        PH_WDAT,
        PH_READ,
        PH_SKIP
    } phase_e;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    typedef struct packed {
        logic [2:0] scl;
        logic [2:0] sda;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.scl = {s_q.scl[1:0], scl_i};
        s_d.sda = {s_q.sda[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{scl: 3'b111, sda: 3'b111};
        else        s_q <= s_d;
    end

    assign scl_s     = s_q.scl[1];
    assign sda_s     = s_q.sda[1];
    assign scl_rise  = s_q.scl[1] & ~s_q.scl[2];
    assign scl_fall  = ~s_q.scl[1] & s_q.scl[2];
    assign bus_start = s_q.scl[1] & s_q.scl[2] & ~s_q.sda[1] & s_q.sda[2];
    assign bus_stop  = s_q.scl[1] & s_q.scl[2] & s_q.sda[1] & ~s_q.sda[2];
endmodule

// File: rtl/i2c_rt_engine.sv
module i2c_rt_engine
    import i2c_rt_pkg::*;
#(
    parameter logic [6:0] CHIP_ADDR = 7'h38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             sda_s,
    input  logic [7:0]       rdata,
    output logic [SUB_W-1:0] reg_addr,
    output logic             reg_lane,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    output logic             sda_oe
);
    typedef struct packed {
        phase_e           st;
        logic             ack;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic [SUB_W-1:0] ptr;
        logic             lane;
        logic             rw;
        logic             mack;
        logic             oe;
    } eng_t;

    eng_t q, n;
    logic word_rgn;
    logic we_d;

    assign word_rgn = (q.ptr >= WORD_BASE);

    always_comb begin
        n    = q;
        we_d = 1'b0;
        if (bus_start) begin
            n.st  = PH_ADDR;
            n.cnt = '0;
            n.ack = 1'b0;
            n.oe  = 1'b0;
        end else if (bus_stop) begin
            n.st  = PH_IDLE;
            n.cnt = '0;
            n.ack = 1'b0;
            n.oe  = 1'b0;
        end else if (q.st == PH_IDLE || q.st == PH_SKIP) begin
            n.oe = 1'b0;
        end else if (q.st == PH_READ) begin
            if (scl_rise) begin
                if (q.ack) begin
                    n.mack = ~sda_s;
                    if (!sda_s) begin
                        if (word_rgn && !q.lane) n.lane = 1'b1;
                        else begin
                            n.lane = 1'b0;
                            n.ptr  = q.ptr + 1'b1;
                        end
                    end
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end else if (scl_fall) begin
                if (q.ack) begin
                    n.ack = 1'b0;
                    n.cnt = '0;
                    if (q.mack) begin
                        n.sh = rdata;
                        n.oe = ~rdata[7];
                    end else begin
                        n.st = PH_SKIP;
                        n.oe = 1'b0;
                    end
                end else if (q.cnt == 4'd8) begin
                    n.ack = 1'b1;
                    n.oe  = 1'b0;
                end else if (q.cnt != 4'd0) begin
                    n.sh = {q.sh[6:0], 1'b0};
                    n.oe = ~q.sh[6];
                end
            end
        end else begin
            if (scl_rise && !q.ack && q.cnt < 4'd8) begin
                n.sh  = {q.sh[6:0], sda_s};
                n.cnt = q.cnt + 1'b1;
            end else if (scl_fall && q.ack) begin
                n.ack = 1'b0;
                n.oe  = 1'b0;
                n.cnt = '0;
                case (q.st)
                    PH_ADDR: begin
                        if (q.rw) begin
                            n.st = PH_READ;
                            n.sh = rdata;
                            n.oe = ~rdata[7];
                        end else begin
                            n.st = PH_SUBH;
                        end
                    end
                    PH_SUBH: n.st = PH_SUBL;
                    PH_SUBL: n.st = PH_WDAT;
                    default: n.st = q.st;
                endcase
            end else if (scl_fall && q.cnt == 4'd8) begin
                n.ack = 1'b1;
                n.oe  = 1'b1;
                case (q.st)
                    PH_ADDR: begin
                        if (q.sh[7:1] == CHIP_ADDR) begin
                            n.rw = q.sh[0];
                        end else begin
                            n.st  = PH_SKIP;
                            n.ack = 1'b0;
                            n.oe  = 1'b0;
                        end
                    end
                    PH_SUBH: n.ptr[15:8] = q.sh;
                    PH_SUBL: begin
                        n.ptr[7:0] = q.sh;
                        n.lane     = 1'b0;
                    end
                    default: begin
                        we_d = 1'b1;
                        if (word_rgn && !q.lane) n.lane = 1'b1;
                        else begin
                            n.lane = 1'b0;
                            n.ptr  = q.ptr + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PH_IDLE, default: '0};
        else        q <= n;
    end

    assign reg_addr  = q.ptr;
    assign reg_lane  = q.lane;
    assign reg_wdata = q.sh;
    assign reg_we    = we_d;
    assign sda_oe    = q.oe;

    // R5
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !word_rgn) |=> (q.ptr == $past(q.ptr) + 16'd1));

    // R3
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_SKIP) |-> (!reg_we && !sda_oe));

    // R8
    nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_READ && q.ack && scl_rise && sda_s && !bus_start && !bus_stop)
        |=> ($stable(q.ptr) && $stable(q.lane)));
endmodule

// File: rtl/i2c_rt_store.sv
module i2c_rt_store
    import i2c_rt_pkg::*;
#(
    parameter int LO_AW = 4,
    parameter int HI_AW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUB_W-1:0] addr,
    input  logic             lane,
    input  logic [7:0]       wdata,
    input  logic             we,
    output logic [7:0]       rdata
);
    localparam int LO_N = 1 << LO_AW;
    localparam int HI_N = 1 << HI_AW;

    logic [LO_N-1:0][7:0]  lo_d, lo_q;
    logic [HI_N-1:0][15:0] hi_d, hi_q;
    logic                  in_word;
    logic [LO_AW-1:0]      lo_idx;
    logic [HI_AW-1:0]      hi_idx;

    assign in_word = (addr >= WORD_BASE);
    assign lo_idx  = addr[LO_AW-1:0];
    assign hi_idx  = addr[HI_AW-1:0];

    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        if (we) begin
            if (!in_word)  lo_d[lo_idx]        = wdata;
            else if (lane) hi_d[hi_idx][7:0]   = wdata;
            else           hi_d[hi_idx][15:8]  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign rdata = !in_word ? lo_q[lo_idx]
                 : (lane ? hi_q[hi_idx][7:0] : hi_q[hi_idx][15:8]);

    // R6
    lane_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !in_word) |-> !lane);
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_rt_pkg::*;
#(
    parameter logic [6:0] CHIP_ADDR = 7'h38,
    parameter int         LO_AW     = 4,
    parameter int         HI_AW     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    logic             scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [SUB_W-1:0] reg_addr;
    logic             reg_lane, reg_we;
    logic [7:0]       reg_wdata, reg_rdata;

    i2c_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_rt_engine #(.CHIP_ADDR(CHIP_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s),
        .rdata(reg_rdata), .reg_addr(reg_addr), .reg_lane(reg_lane),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .sda_oe(sda_oe)
    );

    i2c_rt_store #(.LO_AW(LO_AW), .HI_AW(HI_AW)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .lane(reg_lane),
        .wdata(reg_wdata), .we(reg_we), .rdata(reg_rdata)
    );

    // R10
    oe_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop || bus_start) |=> !sda_oe);
endmodule

// File: tb/i2c_regfile_target_test.sv
module i2c_regfile_target_test;
    localparam int CLK_NS = 10;
    localparam int Q      = 6;
    localparam logic [6:0] OWN = 7'h38;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    int   checks = 0;
    int   fails  = 0;
    bit   quiet  = 1'b1;
    int   hi_cnt = 0;
    logic oe_prev = 1'b0;
    bit   done = 1'b0;

    logic [7:0]  m_lo [16];
    logic [15:0] m_hi [8];
    logic [15:0] m_ptr = '0;
    logic        m_lane = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;
    always #(CLK_NS/2) clk = ~clk;

    i2c_regfile_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read();
        if (m_ptr < 16'h4000) return m_lo[m_ptr[3:0]];
        return m_lane ? m_hi[m_ptr[2:0]][7:0] : m_hi[m_ptr[2:0]][15:8];
    endfunction

    function automatic void m_step();
        if (m_ptr >= 16'h4000 && !m_lane) m_lane = 1'b1;
        else begin
            m_lane = 1'b0;
            m_ptr  = m_ptr + 16'd1;
        end
    endfunction

    function automatic void m_write(input logic [7:0] b);
        if (m_ptr < 16'h4000) m_lo[m_ptr[3:0]] = b;
        else if (m_lane)      m_hi[m_ptr[2:0]][7:0] = b;
        else                  m_hi[m_ptr[2:0]][15:8] = b;
        m_step();
    endfunction

    // per-clock comparison: silent when expected, steady while SCL high
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (scl_m) hi_cnt++; else hi_cnt = 0;
            checks++;
            if (quiet && sda_oe) begin
                fails++;
                $display("FAIL R1 actual=%0d expected=0 (sda_oe while silent)", sda_oe);
            end else if (hi_cnt > 4 && sda_oe != oe_prev) begin
                fails++;
                $display("FAIL R10 actual=%0d expected=%0d (sda_oe moved, SCL high)", sda_oe, oe_prev);
            end
            oe_prev = sda_oe;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
        quiet = 1'b1;
    endtask

    task automatic send(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        acked = ~sda_bus;
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_bus;
            scl_m = 1'b0;
        end
        wq(Q);
        sda_m = give_ack ? 1'b0 : 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic header(input logic [15:0] sub, input string req);
        logic a;
        quiet = 1'b0;
        bus_start();
        send({OWN, 1'b0}, a); chk({req, "/R2 addr ack"}, a, 1);
        send(sub[15:8], a);   chk({req, "/R4 sub hi ack"}, a, 1);
        send(sub[7:0], a);    chk({req, "/R4 sub lo ack"}, a, 1);
        m_ptr = sub; m_lane = 1'b0;
    endtask

    task automatic wr_burst(input logic [15:0] sub, input logic [7:0] d[$], input string req);
        logic a;
        header(sub, req);
        foreach (d[k]) begin
            send(d[k], a); chk({req, " data ack"}, a, 1);
            m_write(d[k]);
        end
        bus_stop();
    endtask

    task automatic rd_bytes(input int n, input string req);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv(k != n-1, b);
            chk(req, b, m_read());
            if (k != n-1) m_step();
        end
    endtask

    task automatic rd_at(input logic [15:0] sub, input int n, input string req);
        logic a;
        header(sub, req);
        bus_start();
        send({OWN, 1'b1}, a); chk({req, "/R7 read addr ack"}, a, 1);
        rd_bytes(n, req);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_lo[i] = '0;
        for (int i = 0; i < 8; i++)  m_hi[i] = '0;
        fork
            begin
                wq(180000);
                if (!done) begin
                    fails++;
                    $display("FAIL watchdog actual=timeout expected=finish");
                    done = 1'b1;
                    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                    $finish;
                end
            end
        join_none
        wq(4);
        rst_n = 1'b1;
        wq(4);
        chk("R1 reset sda_oe", sda_oe, 0);

        // R4 R5: byte-region burst write, then burst read via repeated start
        wr_burst(16'h0003, '{8'hA1, 8'hB2, 8'hC3}, "R5 byte write");
        rd_at(16'h0003, 3, "R7 byte burst read");

        // R8: last byte NACKed, pointer stays; R9: read resumes after stop without subaddress
        begin
            logic a;
            logic [7:0] b;
            quiet = 1'b0;
            bus_start();
            send({OWN, 1'b1}, a); chk("R9 resume addr ack", a, 1);
            recv(1'b0, b); chk("R8 R9 same byte after NACK", b, m_read());
            bus_stop();
        end

        // R3: foreign address, nothing acked or stored
        begin
            logic a;
            bus_start();
            send({7'h11, 1'b0}, a); chk("R3 foreign addr nack", a, 0);
            send(8'h00, a);          chk("R3 later byte nack", a, 0);
            send(8'h03, a);          chk("R3 later byte nack", a, 0);
            send(8'hFF, a);          chk("R3 later byte nack", a, 0);
            bus_stop();
        end
        rd_at(16'h0003, 1, "R3 register unchanged");

        // R5: byte region aliases on low bits, pointer wraps within region index
        wr_burst(16'h001E, '{8'h5A, 8'h6B, 8'h7C}, "R5 alias write");
        rd_at(16'h000E, 3, "R5 alias read");

        // R6: word region, two bytes per word, MSB first
        wr_burst(16'h4002, '{8'h12, 8'h34, 8'h56, 8'h78}, "R6 word write");
        rd_at(16'h4002, 4, "R6 word read");
        rd_at(16'h4003, 2, "R6 second word read");
        rd_at(16'h4002, 3, "R6 R8 word read nack");
        begin
            logic a;
            logic [7:0] b;
            quiet = 1'b0;
            bus_start();
            send({OWN, 1'b1}, a); chk("R8 word resume ack", a, 1);
            recv(1'b0, b); chk("R8 word byte repeated", b, m_read());
            bus_stop();
        end

        wq(20);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule